// File: doc/BRIEF.md
# Extended-Precision Condition Code Classifier

This block inspects one 80-bit extended-precision floating-point value and records four condition bits in a registered status word. The value arrives as a 16-bit word that holds the sign bit above a 15-bit biased exponent, and as a 64-bit significand whose top bit is the explicit integer bit. When the load strobe is high, the block clears its negative, zero, infinity and not-a-number bits together and sets each one again from the new value. All other bits of the status word keep their contents.

A separate write strobe replaces the whole status word from a write-data port, so the bits outside the four flags can be set. If both strobes are high in one cycle, the write wins. The block does no arithmetic, no rounding and no trapping. It only classifies the value and updates the flags.

Top module: `fp_cond_classifier`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) clears the whole 32-bit status word to 0.
- R2: On a load (loadEn high, wrEn low), only the four flag bits change: negative at bit 27, zero at bit 26, infinity at bit 25 and NaN at bit 24. Every other status bit keeps its value.
- R3: After a load, the negative bit equals bit 15 of signExp, whatever the class of the value, including zero, infinity and NaN.
- R4: After a load, the zero bit is set exactly when signExp[14:0] is 0 and significand bits 62..0 are all 0. The integer bit (bit 63) does not affect it.
- R5: After a load, the infinity bit is set exactly when signExp[14:0] is 0x7FFF and significand bits 62..0 are all 0. The integer bit does not affect it.
- R6: After a load, the NaN bit is set exactly when signExp[14:0] is 0x7FFF and significand bits 62..0 are not all 0. Quiet NaNs (bit 62 = 1) and signaling NaNs (bit 62 = 0) both count.
- R7: After any load, the infinity and NaN bits are never both 1.
- R8: On a write (wrEn high), the status word takes the value of wrData at the next rising edge.
- R9: When wrEn and loadEn are both high in one cycle, the write is applied and the load is ignored.
- R10: With neither strobe high and reset low, the status word holds its value.
- R11: A load clears any flag that the new value does not call for, even one that an earlier load or write had set. A denormal (exponent 0, nonzero fraction) therefore leaves only the negative bit, and only when its sign is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| loadEn | input | 1 | Classify the value and update the four flags |
| signExp | input | 16 | Sign bit (15) above the biased exponent (14..0) |
| mant | input | 64 | Significand, with the explicit integer bit at 63 |
| wrEn | input | 1 | Replace the whole status word from wrData |
| wrData | input | 32 | Status word to write |
| status | output | 32 | Registered status word |

## Verification
Some rules are checked by the assertions on every cycle. These are: the status word holds when no strobe is high, a write lands in full and wins over a load, a load leaves the non-flag bits alone, the negative bit follows the sign bit, and infinity and NaN are never set together. Only the bench's directed scenarios can show which class each kind of value gets. These include a zero with the integer bit set, a pseudo-infinity with the integer bit clear, denormals, and quiet and signaling NaNs. The scenarios also show that flags set by an earlier write are cleared by the next load.

// File: rtl/fp_cond_pkg.sv
package fp_cond_pkg;
  // strobes that the control passes to the datapath
  typedef struct packed {
    logic doWrite;
    logic doLoad;
  } ctlStrobes_t;

  // classification result, in the order neg, zero, inf, nan
  typedef struct packed {
    logic neg;
    logic zero;
    logic inf;
    logic nan;
  } fpClass_t;
endpackage

// File: rtl/fp_cond_ctrl.sv
module fp_cond_ctrl
  import fp_cond_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        loadEn,
  input  logic        wrEn,
  output ctlStrobes_t strobes
);
  always_comb begin
    strobes.doWrite = wrEn & ~rst;
    strobes.doLoad  = loadEn & ~wrEn & ~rst;
  end

  // R9
  wr_over_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && loadEn) |-> (strobes.doWrite && !strobes.doLoad));
endmodule

// File: rtl/fp_cond_classify.sv
module fp_cond_classify
  import fp_cond_pkg::*;
#(
  parameter int EXP_W  = 15,
  parameter int MANT_W = 64
) (
  input  logic [EXP_W:0]    signExp,
  input  logic [MANT_W-1:0] mant,
  output fpClass_t          cls
);
  localparam int FRAC_W = MANT_W - 1;

  logic [EXP_W-1:0] expField;
  logic             expZero;
  logic             expOnes;
  logic             fracZero;

  always_comb begin
    expField = signExp[EXP_W-1:0];
    expZero  = ~|expField;
    expOnes  = &expField;
    // the integer bit is left out of the fraction test
    fracZero = ~|mant[FRAC_W-1:0];
    cls.neg  = signExp[EXP_W];
    cls.zero = expZero & fracZero;
    cls.inf  = expOnes & fracZero;
    cls.nan  = expOnes & ~fracZero;
  end
endmodule

// File: rtl/fp_cond_status.sv
module fp_cond_status
  import fp_cond_pkg::*;
#(
  parameter int STATUS_W = 32,
  parameter int NEG_POS  = 27,
  parameter int ZERO_POS = 26,
  parameter int INF_POS  = 25,
  parameter int NAN_POS  = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  ctlStrobes_t         strobes,
  input  fpClass_t            cls,
  input  logic [STATUS_W-1:0] wrData,
  output logic [STATUS_W-1:0] status
);
  localparam logic [STATUS_W-1:0] FLAG_MASK =
    (STATUS_W'(1) << NEG_POS) | (STATUS_W'(1) << ZERO_POS) |
    (STATUS_W'(1) << INF_POS) | (STATUS_W'(1) << NAN_POS);

  logic [STATUS_W-1:0] flagBits;
  logic [STATUS_W-1:0] nextStatus;

  always_comb begin
    flagBits = '0;
    flagBits[NEG_POS]  = cls.neg;
    flagBits[ZERO_POS] = cls.zero;
    flagBits[INF_POS]  = cls.inf;
    flagBits[NAN_POS]  = cls.nan;
    if (strobes.doWrite)
      nextStatus = wrData;
    else if (strobes.doLoad)
      nextStatus = (status & ~FLAG_MASK) | flagBits;
    else
      nextStatus = status;
  end

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= nextStatus;
  end

  // R2
  keep_other_bits_chk: assert property (@(posedge clk) disable iff (rst)
    $past(strobes.doLoad) && !$past(rst) |->
      ((status & ~FLAG_MASK) == ($past(status) & ~FLAG_MASK)));
  // R7
  inf_nan_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $past(strobes.doLoad) && !$past(rst) |-> !(status[INF_POS] && status[NAN_POS]));
  // R8
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    $past(strobes.doWrite) && !$past(rst) |-> status == $past(wrData));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(strobes.doWrite) && !$past(strobes.doLoad) && !$past(rst) |-> $stable(status));
endmodule

// File: rtl/fp_cond_classifier.sv
module fp_cond_classifier
  import fp_cond_pkg::*;
#(
  parameter int EXP_W    = 15,
  parameter int MANT_W   = 64,
  parameter int STATUS_W = 32,
  parameter int NEG_POS  = 27,
  parameter int ZERO_POS = 26,
  parameter int INF_POS  = 25,
  parameter int NAN_POS  = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                loadEn,
  input  logic [EXP_W:0]      signExp,
  input  logic [MANT_W-1:0]   mant,
  input  logic                wrEn,
  input  logic [STATUS_W-1:0] wrData,
  output logic [STATUS_W-1:0] status
);
  ctlStrobes_t strobes;
  fpClass_t    cls;

  fp_cond_ctrl u_ctrl (
    .clk(clk), .rst(rst), .loadEn(loadEn), .wrEn(wrEn), .strobes(strobes)
  );

  fp_cond_classify #(.EXP_W(EXP_W), .MANT_W(MANT_W)) u_classify (
    .signExp(signExp), .mant(mant), .cls(cls)
  );

  fp_cond_status #(
    .STATUS_W(STATUS_W), .NEG_POS(NEG_POS), .ZERO_POS(ZERO_POS),
    .INF_POS(INF_POS), .NAN_POS(NAN_POS)
  ) u_status (
    .clk(clk), .rst(rst), .strobes(strobes), .cls(cls),
    .wrData(wrData), .status(status)
  );

  // R3
  neg_follows_sign_chk: assert property (@(posedge clk) disable iff (rst)
    $past(loadEn && !wrEn) && !$past(rst) |-> status[NEG_POS] == $past(signExp[EXP_W]));
  // R9
  write_wins_chk: assert property (@(posedge clk) disable iff (rst)
    $past(loadEn && wrEn) && !$past(rst) |-> status == $past(wrData));
endmodule

// File: tb/fp_cond_classifier_test.sv
module fp_cond_classifier_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        loadEn = 1'b0;
  logic [15:0] signExp = '0;
  logic [63:0] mant = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] status;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] model = '0;
  localparam logic [31:0] FMASK = 32'h0F00_0000;

  fp_cond_classifier uut (
    .clk(clk), .rst(rst), .loadEn(loadEn), .signExp(signExp), .mant(mant),
    .wrEn(wrEn), .wrData(wrData), .status(status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected under 5000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] exp);
    checks++;
    if (status !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, status, exp);
    end
  endtask

  // flags: {neg, zero, inf, nan} -> status bits 27..24
  task automatic load_value(input string req, input logic [15:0] se,
                            input logic [63:0] m, input logic [3:0] flags);
    @(negedge clk);
    signExp = se; mant = m; loadEn = 1'b1;
    @(negedge clk);
    loadEn = 1'b0;
    model = (model & ~FMASK) | {4'b0, flags, 24'b0};
    check(req, model);
  endtask

  task automatic write_word(input string req, input logic [31:0] w);
    @(negedge clk);
    wrData = w; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    model = w;
    check(req, model);
  endtask

  task automatic test_reset;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model = '0;
    check("R1 reset", model);
  endtask

  task automatic test_normals;
    load_value("R3 positive normal", 16'h3FFF, 64'h8000_0000_0000_0000, 4'b0000);
    load_value("R3 negative normal", 16'hC000, 64'hC000_0000_0000_0000, 4'b1000);
  endtask

  task automatic test_zeros;
    load_value("R4 +zero", 16'h0000, 64'h0, 4'b0100);
    load_value("R4 -zero int bit set", 16'h8000, 64'h8000_0000_0000_0000, 4'b1100);
  endtask

  task automatic test_denormal;
    load_value("R11 +denormal", 16'h0000, 64'h0000_0000_0000_0001, 4'b0000);
    load_value("R11 -denormal", 16'h8000, 64'h4000_0000_0000_0000, 4'b1000);
  endtask

  task automatic test_infinity;
    load_value("R5 +inf", 16'h7FFF, 64'h8000_0000_0000_0000, 4'b0010);
    load_value("R5 -inf int bit clear", 16'hFFFF, 64'h0, 4'b1010);
  endtask

  task automatic test_nans;
    load_value("R6 quiet nan", 16'h7FFF, 64'hC000_0000_0000_0000, 4'b0001);
    load_value("R6 signaling nan neg", 16'hFFFF, 64'h8000_0000_0000_0001, 4'b1001);
    load_value("R7 nan int bit clear", 16'h7FFF, 64'h0000_0000_0001_0000, 4'b0001);
  endtask

  task automatic test_write_and_keep;
    write_word("R8 write all ones", 32'hFFFF_FFFF);
    // load clears stale flags and keeps other bits
    load_value("R2 load keeps other bits", 16'h3FFF, 64'h8000_0000_0000_0000, 4'b0000);
    if ((status & ~FMASK) !== 32'hF0FF_FFFF) begin
      errors++;
      $display("FAIL R2: actual %h expected %h", status & ~FMASK, 32'hF0FF_FFFF);
    end
    checks++;
  endtask

  task automatic test_priority;
    @(negedge clk);
    wrData = 32'h1234_5678; wrEn = 1'b1;
    signExp = 16'hFFFF; mant = 64'h0; loadEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; loadEn = 1'b0;
    model = 32'h1234_5678;
    check("R9 write over load", model);
  endtask

  task automatic test_hold;
    @(negedge clk);
    signExp = 16'h0000; mant = 64'h0;
    repeat (3) @(negedge clk);
    check("R10 hold", model);
  endtask

  initial begin
    test_reset();
    test_normals();
    test_zeros();
    test_denormal();
    test_infinity();
    test_nans();
    test_write_and_keep();
    test_priority();
    test_hold();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model = '0;
    check("R1 reset after use", model);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule